// File: doc/BRIEF.md
# Scoreboard Issue and Dispatch Controller

This block controls issue and dispatch for an out-of-order core that keeps one busy bit per architectural register and a single shared instruction window. A decoded instruction brings two source register ids, one destination register id and a functional unit type. If the instruction is accepted, it takes a free window slot and waits there until both of its sources are available. The controller then sends it to the functional units. Instructions can leave the window in any order.

Each hazard is handled at its own point. Write-after-write is caught at issue: an instruction cannot enter while its destination already has a pending update, so each register has at most one write in flight. Read-after-write is resolved in the window, because only entries with both sources available can be dispatched. Write-after-read is caught at writeback: a finished unit asks to write its register, and the controller withholds the grant while an older instruction still in the window needs the previous value of that register.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset every register is idle and the window is empty. `dsp_valid` and `wb_grant` are low, and `iss_stall` is low for any instruction whose unit type is available.
- R2: `iss_stall` is high while the destination register has a pending write. An accepted instruction (`iss_valid` high, `iss_stall` low) marks its destination pending from the next cycle. A granted writeback clears that mark from the next cycle.
- R3: `iss_stall` is high when bit `iss_unit` of `unit_avail` is low.
- R4: `iss_stall` is high while the window holds DEPTH entries (8 by default).
- R5: An entry is dispatched only when both of its sources are available. A source is available at issue if its register has no pending write, or if that register's writeback is granted in the same cycle.
- R6: Among the available entries, the one that was accepted earliest is dispatched. At most one entry is dispatched per cycle. An older entry that is still waiting does not block a younger entry that is ready.
- R7: During the dispatch cycle, `dsp_src0`, `dsp_src1`, `dsp_dst` and `dsp_unit` show the fields of the chosen entry. An instruction accepted at a clock edge can be dispatched in the cycle that begins at that edge, and it leaves the window at the following edge.
- R8: `wb_grant` is asserted in the same cycle as `wb_req` unless some window entry has a source equal to `wb_dst` that is already marked available. In that case the grant is withheld until no such entry remains.
- R9: A granted writeback marks every waiting source that names `wb_dst` as available from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | A decoded instruction is offered |
| iss_src0 | input | 5 | First source register id |
| iss_src1 | input | 5 | Second source register id |
| iss_dst | input | 5 | Destination register id |
| iss_unit | input | 2 | Functional unit type |
| unit_avail | input | 4 | One bit per unit type, high when that type can take new work |
| iss_stall | output | 1 | Offered instruction cannot be accepted this cycle |
| dsp_valid | output | 1 | An entry is dispatched this cycle |
| dsp_src0 | output | 5 | First source of the dispatched entry |
| dsp_src1 | output | 5 | Second source of the dispatched entry |
| dsp_dst | output | 5 | Destination of the dispatched entry |
| dsp_unit | output | 2 | Unit type of the dispatched entry |
| wb_req | input | 1 | A unit has finished and asks to write back |
| wb_dst | input | 5 | Register the finished unit wants to write |
| wb_grant | output | 1 | The writeback may proceed this cycle |

## Verification
Internal state errors show up at the ports within a cycle or two. A busy bit that is wrongly cleared lets a second writer through when `iss_stall` should have held it. A busy bit that is never cleared blocks issue permanently. If an available flag is missed, the consumer never reaches `dsp_valid`. If an age stamp is wrong, the dispatched fields come out in the wrong order as soon as two ready entries compete. If the source-readiness state in the window is corrupted, `wb_grant` asserts while an older reader is still waiting, or it stays low indefinitely. The bench tracks its own model of the busy bits and the window and compares every stall, dispatch and grant decision against it cycle by cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int unsigned SB_NREG_DEF  = 32;
   localparam int unsigned SB_DEPTH_DEF = 8;
   localparam int unsigned SB_NUNIT_DEF = 4;

   // index width for a count of n items, never below one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/sb_busy_tbl.sv
module sb_busy_tbl
   import sb_pkg::*;
#(
   parameter int unsigned NREG = SB_NREG_DEF,
   localparam int unsigned RW = idx_w(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_en,
   input  logic [RW-1:0]   set_id,
   input  logic            clr_en,
   input  logic [RW-1:0]   clr_id,
   output logic [NREG-1:0] busy
);

   for (genvar g = 0; g < NREG; g++) begin : g_bit
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_q <= 1'b0;
         else if (set_en && set_id == RW'(g))
            pend_q <= 1'b1;
         else if (clr_en && clr_id == RW'(g))
            pend_q <= 1'b0;
      end
      assign busy[g] = pend_q;
   end

endmodule

// File: rtl/sb_window.sv
module sb_window
   import sb_pkg::*;
#(
   parameter int unsigned NREG  = SB_NREG_DEF,
   parameter int unsigned DEPTH = SB_DEPTH_DEF,
   parameter int unsigned NUNIT = SB_NUNIT_DEF,
   localparam int unsigned RW = idx_w(NREG),
   localparam int unsigned IW = idx_w(DEPTH),
   localparam int unsigned UW = idx_w(NUNIT),
   localparam int unsigned AW = IW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc_en,
   input  logic [RW-1:0]       a_src0,
   input  logic [RW-1:0]       a_src1,
   input  logic [RW-1:0]       a_dst,
   input  logic [UW-1:0]       a_unit,
   input  logic                a_rdy0,
   input  logic                a_rdy1,
   input  logic                wb_en,
   input  logic [RW-1:0]       wb_id,
   input  logic                take_en,
   input  logic [IW-1:0]       take_idx,
   output logic [DEPTH-1:0]    ent_ready,
   output logic [DEPTH*AW-1:0] ent_age,
   output logic [IW:0]         occ,
   output logic                full,
   output logic                war_hit,
   output logic [RW-1:0]       o_src0,
   output logic [RW-1:0]       o_src1,
   output logic [RW-1:0]       o_dst,
   output logic [UW-1:0]       o_unit
);

   localparam logic [IW:0] DEPTH_V = (IW+1)'(DEPTH);

   logic [DEPTH-1:0] vld_q, r0_q, r1_q;
   logic [RW-1:0]    s0_q  [DEPTH];
   logic [RW-1:0]    s1_q  [DEPTH];
   logic [RW-1:0]    d_q   [DEPTH];
   logic [UW-1:0]    u_q   [DEPTH];
   logic [AW-1:0]    age_q [DEPTH];
   logic [IW:0]      occ_q;
   logic [IW-1:0]    free_idx;
   logic [AW-1:0]    take_age;
   logic [AW-1:0]    new_age;

   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (!vld_q[i]) free_idx = IW'(i);
   end

   assign take_age = age_q[take_idx];
   assign new_age  = AW'(occ_q - {{IW{1'b0}}, take_en});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         r0_q  <= '0;
         r1_q  <= '0;
         occ_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            s0_q[i]  <= '0;
            s1_q[i]  <= '0;
            d_q[i]   <= '0;
            u_q[i]   <= '0;
            age_q[i] <= '0;
         end
      end else begin
         occ_q <= occ_q + (IW+1)'(alloc_en) - (IW+1)'(take_en);
         for (int i = 0; i < DEPTH; i++) begin
            if (take_en && take_idx == IW'(i)) begin
               vld_q[i] <= 1'b0;
            end else if (vld_q[i]) begin
               if (take_en && age_q[i] > take_age)
                  age_q[i] <= age_q[i] - 1'b1;
               if (wb_en && s0_q[i] == wb_id) r0_q[i] <= 1'b1;
               if (wb_en && s1_q[i] == wb_id) r1_q[i] <= 1'b1;
            end
            if (alloc_en && free_idx == IW'(i)) begin
               vld_q[i] <= 1'b1;
               s0_q[i]  <= a_src0;
               s1_q[i]  <= a_src1;
               d_q[i]   <= a_dst;
               u_q[i]   <= a_unit;
               r0_q[i]  <= a_rdy0;
               r1_q[i]  <= a_rdy1;
               age_q[i] <= new_age;
            end
         end
      end
   end

   assign ent_ready = vld_q & r0_q & r1_q;
   for (genvar g = 0; g < DEPTH; g++) begin : g_age
      assign ent_age[g*AW +: AW] = age_q[g];
   end

   always_comb begin
      war_hit = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (vld_q[i] && ((r0_q[i] && s0_q[i] == wb_id) ||
                          (r1_q[i] && s1_q[i] == wb_id)))
            war_hit = 1'b1;
   end

   assign occ    = occ_q;
   assign full   = (occ_q == DEPTH_V);
   assign o_src0 = s0_q[take_idx];
   assign o_src1 = s1_q[take_idx];
   assign o_dst  = d_q[take_idx];
   assign o_unit = u_q[take_idx];

endmodule

// File: rtl/sb_pick.sv
module sb_pick
   import sb_pkg::*;
#(
   parameter int unsigned DEPTH        = SB_DEPTH_DEF,
   parameter int unsigned AW           = 3,
   parameter bit          OLDEST_FIRST = 1'b1,
   localparam int unsigned IW = idx_w(DEPTH)
) (
   input  logic [DEPTH-1:0]    req,
   input  logic [DEPTH*AW-1:0] age,
   output logic [DEPTH-1:0]    gnt,
   output logic [IW-1:0]       idx,
   output logic                any
);

   if (OLDEST_FIRST) begin : g_oldest
      always_comb begin
         for (int i = 0; i < DEPTH; i++) begin
            gnt[i] = req[i];
            for (int j = 0; j < DEPTH; j++)
               if (j != i && req[j] && age[j*AW +: AW] < age[i*AW +: AW])
                  gnt[i] = 1'b0;
         end
      end
   end else begin : g_lowest
      always_comb begin
         logic seen;
         seen = 1'b0;
         for (int i = 0; i < DEPTH; i++) begin
            gnt[i] = req[i] && !seen;
            if (req[i]) seen = 1'b1;
         end
      end
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < DEPTH; i++)
         if (gnt[i]) idx = idx | IW'(i);
   end

   assign any = |req;

endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
   import sb_pkg::*;
#(
   parameter int unsigned NREG         = SB_NREG_DEF,
   parameter int unsigned DEPTH        = SB_DEPTH_DEF,
   parameter int unsigned NUNIT        = SB_NUNIT_DEF,
   parameter bit          OLDEST_FIRST = 1'b1,
   localparam int unsigned RW = idx_w(NREG),
   localparam int unsigned IW = idx_w(DEPTH),
   localparam int unsigned UW = idx_w(NUNIT),
   localparam int unsigned AW = IW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iss_valid,
   input  logic [RW-1:0]    iss_src0,
   input  logic [RW-1:0]    iss_src1,
   input  logic [RW-1:0]    iss_dst,
   input  logic [UW-1:0]    iss_unit,
   input  logic [NUNIT-1:0] unit_avail,
   output logic             iss_stall,
   output logic             dsp_valid,
   output logic [RW-1:0]    dsp_src0,
   output logic [RW-1:0]    dsp_src1,
   output logic [RW-1:0]    dsp_dst,
   output logic [UW-1:0]    dsp_unit,
   input  logic             wb_req,
   input  logic [RW-1:0]    wb_dst,
   output logic             wb_grant
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sb_issue_ctrl: DEPTH must be a power of two, at least 2");
   end
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("sb_issue_ctrl: NREG must be a power of two, at least 2");
   end
   if (NUNIT < 2 || (NUNIT & (NUNIT - 1)) != 0) begin : g_bad_nunit
      $error("sb_issue_ctrl: NUNIT must be a power of two, at least 2");
   end

   logic [NREG-1:0]     busy_q;
   logic [DEPTH-1:0]    ent_ready;
   logic [DEPTH*AW-1:0] ent_age;
   logic [DEPTH-1:0]    pick_gnt;
   logic [IW-1:0]       pick_idx;
   logic [IW:0]         occ;
   logic                full;
   logic                war_hit;
   logic                accept;
   logic                rdy0, rdy1;

   // write-after-write and structural checks at issue
   assign iss_stall = busy_q[iss_dst] | ~unit_avail[iss_unit] | full;
   assign accept    = iss_valid & ~iss_stall;

   // write-after-read check at writeback
   assign wb_grant  = wb_req & ~war_hit;

   assign rdy0 = ~busy_q[iss_src0] | (wb_grant && wb_dst == iss_src0);
   assign rdy1 = ~busy_q[iss_src1] | (wb_grant && wb_dst == iss_src1);

   sb_busy_tbl #(.NREG(NREG)) u_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (accept),
      .set_id (iss_dst),
      .clr_en (wb_grant),
      .clr_id (wb_dst),
      .busy   (busy_q)
   );

   sb_window #(.NREG(NREG), .DEPTH(DEPTH), .NUNIT(NUNIT)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (accept),
      .a_src0    (iss_src0),
      .a_src1    (iss_src1),
      .a_dst     (iss_dst),
      .a_unit    (iss_unit),
      .a_rdy0    (rdy0),
      .a_rdy1    (rdy1),
      .wb_en     (wb_grant),
      .wb_id     (wb_dst),
      .take_en   (dsp_valid),
      .take_idx  (pick_idx),
      .ent_ready (ent_ready),
      .ent_age   (ent_age),
      .occ       (occ),
      .full      (full),
      .war_hit   (war_hit),
      .o_src0    (dsp_src0),
      .o_src1    (dsp_src1),
      .o_dst     (dsp_dst),
      .o_unit    (dsp_unit)
   );

   sb_pick #(.DEPTH(DEPTH), .AW(AW), .OLDEST_FIRST(OLDEST_FIRST)) u_pick (
      .req (ent_ready),
      .age (ent_age),
      .gnt (pick_gnt),
      .idx (pick_idx),
      .any (dsp_valid)
   );

endmodule

// File: rtl/sb_issue_ctrl_chk.sv
module sb_issue_ctrl_chk
   import sb_pkg::*;
#(
   parameter int unsigned NREG  = SB_NREG_DEF,
   parameter int unsigned DEPTH = SB_DEPTH_DEF,
   localparam int unsigned RW = idx_w(NREG),
   localparam int unsigned IW = idx_w(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_valid,
   input logic             iss_stall,
   input logic [RW-1:0]    iss_dst,
   input logic             dsp_valid,
   input logic             wb_grant,
   input logic [RW-1:0]    wb_dst,
   input logic [NREG-1:0]  busy,
   input logic [IW:0]      occ,
   input logic [DEPTH-1:0] pick_gnt
);

   localparam logic [IW:0] DEPTH_V = (IW+1)'(DEPTH);

   // R2
   dst_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_stall) |=> busy[$past(iss_dst)]);

   // R2
   dst_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_grant |=> !busy[$past(wb_dst)]);

   // R4
   full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == DEPTH_V) |-> iss_stall);

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= DEPTH_V);

   // R1
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> !dsp_valid);

   // R6
   single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pick_gnt) && (dsp_valid == (pick_gnt != '0)));

endmodule

bind sb_issue_ctrl sb_issue_ctrl_chk #(.NREG(NREG), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_valid (iss_valid),
   .iss_stall (iss_stall),
   .iss_dst   (iss_dst),
   .dsp_valid (dsp_valid),
   .wb_grant  (wb_grant),
   .wb_dst    (wb_dst),
   .busy      (busy_q),
   .occ       (occ),
   .pick_gnt  (pick_gnt)
);

// File: tb/sb_issue_ctrl_tb.sv
module sb_issue_ctrl_tb;
   localparam int NREG  = 32;
   localparam int DEPTH = 8;
   localparam int NUNIT = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       iss_valid = 1'b0;
   logic [4:0] iss_src0 = '0, iss_src1 = '0, iss_dst = '0;
   logic [1:0] iss_unit = '0;
   logic [3:0] unit_avail = '1;
   logic       iss_stall;
   logic       dsp_valid;
   logic [4:0] dsp_src0, dsp_src1, dsp_dst;
   logic [1:0] dsp_unit;
   logic       wb_req = 1'b0;
   logic [4:0] wb_dst = '0;
   logic       wb_grant;

   always #4 clk = ~clk;

   sb_issue_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_src0(iss_src0), .iss_src1(iss_src1),
      .iss_dst(iss_dst), .iss_unit(iss_unit), .unit_avail(unit_avail),
      .iss_stall(iss_stall), .dsp_valid(dsp_valid),
      .dsp_src0(dsp_src0), .dsp_src1(dsp_src1), .dsp_dst(dsp_dst),
      .dsp_unit(dsp_unit), .wb_req(wb_req), .wb_dst(wb_dst),
      .wb_grant(wb_grant)
   );

   int n_chk = 0;
   int n_bad = 0;

   // bench model of the register marks and the window
   bit m_busy [NREG];
   bit m_infl [NREG];
   bit m_v  [DEPTH];
   bit m_r0 [DEPTH];
   bit m_r1 [DEPTH];
   int m_s0 [DEPTH];
   int m_s1 [DEPTH];
   int m_d  [DEPTH];
   int m_u  [DEPTH];
   int m_seq[DEPTH];
   int seq_ctr = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int pick_infl();
      int start = int'($urandom % NREG);
      for (int k = 0; k < NREG; k++)
         if (m_infl[(start + k) % NREG]) return (start + k) % NREG;
      return -1;
   endfunction

   task automatic step(input bit v, input int s0, input int s1, input int d,
                       input int u, input bit [3:0] av, input bit wr, input int wd);
      int  cnt, best, slot, act_f, exp_f;
      bit  e_stall, war, e_gnt, acc;
      string tag;
      @(negedge clk);
      iss_valid  = v;
      iss_src0   = 5'(s0);
      iss_src1   = 5'(s1);
      iss_dst    = 5'(d);
      iss_unit   = 2'(u);
      unit_avail = av;
      wb_req     = wr;
      wb_dst     = 5'(wd);
      #1;
      cnt = 0;
      for (int i = 0; i < DEPTH; i++) if (m_v[i]) cnt++;
      e_stall = m_busy[d] || !av[u] || cnt == DEPTH;
      if (m_busy[d])          tag = "R2";
      else if (!av[u])        tag = "R3";
      else if (cnt == DEPTH)  tag = "R4";
      else                    tag = "R2 R3 R4";
      chk(iss_stall == e_stall, tag, "iss_stall", int'(iss_stall), int'(e_stall));

      best = -1;
      for (int i = 0; i < DEPTH; i++)
         if (m_v[i] && m_r0[i] && m_r1[i] && (best < 0 || m_seq[i] < m_seq[best]))
            best = i;
      chk(dsp_valid == (best >= 0), "R5 R6 R9", "dsp_valid", int'(dsp_valid), int'(best >= 0));
      if (dsp_valid && best >= 0) begin
         act_f = int'({dsp_src0, dsp_src1, dsp_dst, dsp_unit});
         exp_f = (m_s0[best] << 12) | (m_s1[best] << 7) | (m_d[best] << 2) | m_u[best];
         chk(act_f == exp_f, "R6 R7", "dispatch fields", act_f, exp_f);
      end

      war = 0;
      for (int i = 0; i < DEPTH; i++)
         if (m_v[i] && ((m_r0[i] && m_s0[i] == wd) || (m_r1[i] && m_s1[i] == wd)))
            war = 1;
      e_gnt = wr && !war;
      chk(wb_grant == e_gnt, "R8", "wb_grant", int'(wb_grant), int'(e_gnt));

      // advance the model to the state after the coming edge
      acc = v && !e_stall;
      if (e_gnt) begin
         m_busy[wd] = 0;
         m_infl[wd] = 0;
         for (int i = 0; i < DEPTH; i++) if (m_v[i]) begin
            if (m_s0[i] == wd) m_r0[i] = 1;
            if (m_s1[i] == wd) m_r1[i] = 1;
         end
      end
      if (best >= 0) begin
         m_v[best] = 0;
         m_infl[m_d[best]] = 1;
      end
      if (acc) begin
         slot = -1;
         for (int i = 0; i < DEPTH; i++) if (!m_v[i] && slot < 0) slot = i;
         m_v[slot] = 1;
         m_s0[slot] = s0; m_s1[slot] = s1; m_d[slot] = d; m_u[slot] = u;
         m_r0[slot] = !m_busy[s0];
         m_r1[slot] = !m_busy[s1];
         m_seq[slot] = seq_ctr++;
         m_busy[d] = 1;
      end
   endtask

   task automatic idle(input bit wr, input int wd);
      step(0, 0, 0, 0, 0, 4'hF, wr, wd);
   endtask

   task automatic drain(input int n);
      for (int k = 0; k < n; k++) begin
         int r = pick_infl();
         if (r >= 0) idle(1, r); else idle(0, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: quiet after reset
      @(negedge clk);
      iss_dst = 5'd9; iss_unit = 2'd1; unit_avail = 4'hF; #1;
      chk(!iss_stall, "R1", "iss_stall after reset", int'(iss_stall), 0);
      chk(!dsp_valid, "R1", "dsp_valid after reset", int'(dsp_valid), 0);
      chk(!wb_grant,  "R1", "wb_grant after reset",  int'(wb_grant), 0);

      // R3: unavailable unit type stalls
      step(1, 1, 2, 3, 2, 4'b1011, 0, 0);

      // R8: held writeback while an older reader still waits
      step(1, 0, 0, 7, 0, 4'hF, 0, 0);   // writer of r7
      step(1, 6, 7, 9, 1, 4'hF, 0, 0);   // reader of old r6, waits on r7
      step(1, 0, 0, 6, 2, 4'hF, 0, 0);   // new writer of r6
      idle(0, 0);
      idle(1, 6);                         // held
      idle(1, 7);                         // granted, frees the reader (R9)
      idle(1, 6);                         // reader dispatching, still held
      idle(1, 6);                         // granted
      drain(20);

      // R2: second writer to a pending register stalls
      step(1, 1, 1, 12, 0, 4'hF, 0, 0);
      step(1, 2, 2, 12, 1, 4'hF, 0, 0);
      idle(0, 0);
      step(1, 2, 2, 12, 1, 4'hF, 0, 0);
      drain(10);

      // R4 and R9: fill the window with consumers of one pending register
      step(1, 0, 0, 5, 0, 4'hF, 0, 0);
      for (int k = 0; k < DEPTH; k++) step(1, 5, 5, 16 + k, k % 4, 4'hF, 0, 0);
      step(1, 1, 1, 30, 0, 4'hF, 0, 0);
      step(1, 1, 1, 31, 3, 4'hF, 0, 0);
      idle(1, 5);
      for (int k = 0; k < DEPTH + 2; k++) idle(0, 0);   // R6 oldest first
      drain(30);

      // constrained random mix
      for (int c = 0; c < 3000; c++) begin
         bit v  = ($urandom % 10) < 7;
         int s0 = int'($urandom % 12);
         int s1 = int'($urandom % 12);
         int d  = int'($urandom % 12);
         int u  = int'($urandom % 4);
         bit [3:0] av = (($urandom % 4) == 0) ? 4'($urandom) : 4'hF;
         int r = pick_infl();
         bit wr = (r >= 0) && (($urandom % 10) < 6);
         step(v, s0, s1, d, u, av, wr, wr ? r : 0);
      end
      drain(60);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule